// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block is an up/down counter for a timer subsystem. It either advances once per clock or follows a two-phase quadrature encoder. Its count always wraps between zero and a programmable ceiling. Software controls it through a small synchronous register bus. Through that bus it picks the counting source, sets the ceiling, loads the count directly and reads back the count and the direction of the last step.

There are three decoding resolutions. The first counts both edges of phase A only. The second counts both edges of phase B only. The third counts every edge of both phases. The ceiling can be written directly, or it can be staged in a shadow register that loads on an update event. An update event comes from an external strobe or from a self-clearing control bit, and it also re-initializes the count to zero.

The encoder inputs must already be synchronized to the clock. Bus and counter share one clock domain, and reads are combinational from the address.

Top module: `quad_step_counter`

## Requirements
- R1: After reset the count is 0, the direction bit is 0, the control register (address 0) reads 0 and the ceiling (address 2) reads all ones.
- R2: With enable (control bit 0) set and mode field (control bits 4:2) equal to 0, the count goes up by one every clock. Mode values 4 to 7 behave exactly like 0.
- R3: Mode 1 counts each edge of A only, with {A,B} order 00,01,11,10 as forward. A step is upward when the new A level equals B and downward otherwise. Edges of B alone do not change the count.
- R4: Mode 2 counts each edge of B only. A step is upward when the new B level differs from A and downward otherwise. Edges of A alone do not change the count.
- R5: Mode 3 counts one step per single-input edge of either phase, following the forward order 00,01,11,10 of {A,B}. A cycle in which both A and B change leaves the count unchanged.
- R6: An upward step from a count at or above the active ceiling gives 0. A downward step from 0 gives the active ceiling.
- R7: The direction bit (status address 3, bit 0, also on dirOut) becomes 1 after a downward step and 0 after an upward step. It holds when no step occurs.
- R8: When preload (control bit 1) is clear, a ceiling write takes effect on the next cycle. When preload is set, the written value waits in a shadow register until an update event, and the ceiling still reads the old value.
- R9: An update event clears the count to 0 and loads the ceiling from the shadow register. An update event is a pulse on updStrobe or a control write with bit 5 set. Bit 5 always reads back 0.
- R10: A count write (address 1) whose value is above the active ceiling leaves the count unchanged. A write at or below the ceiling loads the count.
- R11: With enable clear, the count and the direction hold. Register writes, including count writes, still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 control, 1 count, 2 ceiling, 3 status |
| busWrData | input | CNT_W | Register write data |
| busRdData | output | CNT_W | Combinational read data for busAddr |
| encA | input | 1 | Encoder phase A, synchronized |
| encB | input | 1 | Encoder phase B, synchronized |
| updStrobe | input | 1 | Update event pulse |
| countOut | output | CNT_W | Current count |
| dirOut | output | 1 | Direction of the last counted step, 1 = down |

## Verification
The properties assume that encA and encB are clean, synchronized levels that change at most once per cycle each. They compare the present encoder levels with the levels one cycle earlier, and the edge detector keeps tracking the phases even during reset. So the first cycle after reset sees the same history the properties do.

The stimulus changes inputs one nanosecond after the rising edge and holds each encoder state for two clocks. It moves both phases together only in the x4 invalid-jump case, which R5 defines. In the x2 modes it never moves both phases in one cycle, because the step rule there leans on the other phase being steady.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CEIL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam logic [2:0] MODE_X2A = 3'd1;
  localparam logic [2:0] MODE_X2B = 3'd2;
  localparam logic [2:0] MODE_X4  = 3'd3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic step;     // take one counting step
    logic down;     // direction of that step
    logic wrCount;  // bus writes the count
    logic wrCeil;   // bus writes the ceiling
    logic ceilNow;  // ceiling write bypasses the shadow
    logic update;   // update event
  } qsc_strobe_t;
endpackage

// File: rtl/qsc_ctrl.sv
module qsc_ctrl
  import qsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [5:0]  ctrlData,
  input  logic        encA,
  input  logic        encB,
  input  logic        updStrobe,
  output qsc_strobe_t stb,
  output logic [5:0]  ctrlReg
);
  logic       enBit;
  logic       preBit;
  logic [2:0] mode;
  logic       prevA;
  logic       prevB;
  logic       edgeA;
  logic       edgeB;
  logic       upA;
  logic       upB;
  logic       ctrlWr;

  assign ctrlWr = busWrEn && (busAddr == ADDR_CTRL);

  // phase history follows the pins even in reset, so no false edge afterwards
  always_ff @(posedge clk) begin
    prevA <= encA;
    prevB <= encB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enBit  <= 1'b0;
      preBit <= 1'b0;
      mode   <= '0;
    end else if (ctrlWr) begin
      enBit  <= ctrlData[0];
      preBit <= ctrlData[1];
      mode   <= ctrlData[4:2];
    end
  end

  assign edgeA = encA ^ prevA;
  assign edgeB = encB ^ prevB;
  // forward order of {A,B}: 00 -> 01 -> 11 -> 10
  assign upA   = (encA == encB);
  assign upB   = (encB != encA);

  always_comb begin
    stb = '0;
    unique case (mode)
      MODE_X2A: begin
        stb.step = edgeA;
        stb.down = !upA;
      end
      MODE_X2B: begin
        stb.step = edgeB;
        stb.down = !upB;
      end
      MODE_X4: begin
        stb.step = edgeA ^ edgeB;
        stb.down = edgeA ? !upA : !upB;
      end
      default: begin
        stb.step = 1'b1;
        stb.down = 1'b0;
      end
    endcase
    stb.step    = stb.step && enBit;
    stb.wrCount = busWrEn && (busAddr == ADDR_COUNT);
    stb.wrCeil  = busWrEn && (busAddr == ADDR_CEIL);
    stb.ceilNow = !preBit;
    stb.update  = updStrobe || (ctrlWr && ctrlData[5]);
  end

  assign ctrlReg = {1'b0, mode, preBit, enBit};
endmodule

// File: rtl/qsc_datapath.sv
module qsc_datapath
  import qsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  qsc_strobe_t      stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic [CNT_W-1:0] ceilActive
);
  localparam logic [CNT_W-1:0] CEIL_RESET = '1;

  logic [CNT_W-1:0] ceilShadow;
  logic [CNT_W-1:0] shadowNext;
  logic [CNT_W-1:0] stepNext;
  logic             loadOk;

  assign shadowNext = stb.wrCeil ? wrData : ceilShadow;
  assign loadOk     = stb.wrCount && (wrData <= ceilActive);

  always_comb begin
    if (stb.down) stepNext = (count == '0) ? ceilActive : count - 1'b1;
    else          stepNext = (count >= ceilActive) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ceilShadow <= CEIL_RESET;
      ceilActive <= CEIL_RESET;
    end else begin
      ceilShadow <= shadowNext;
      if (stb.update)                   ceilActive <= shadowNext;
      else if (stb.wrCeil && stb.ceilNow) ceilActive <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      dir   <= 1'b0;
    end else begin
      if (stb.update)   count <= '0;
      else if (loadOk)  count <= wrData;
      else if (stb.step) count <= stepNext;
      if (stb.step) dir <= stb.down;
    end
  end
endmodule

// File: rtl/quad_step_counter.sv
module quad_step_counter
  import qsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busWrEn,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             encA,
  input  logic             encB,
  input  logic             updStrobe,
  output logic [CNT_W-1:0] countOut,
  output logic             dirOut
);
  localparam int CTRL_W = 6;

  qsc_strobe_t      stb;
  logic [5:0]       ctrlReg;
  logic [CNT_W-1:0] ceilActive;

  qsc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .ctrlData  (busWrData[CTRL_W-1:0]),
    .encA      (encA),
    .encB      (encB),
    .updStrobe (updStrobe),
    .stb       (stb),
    .ctrlReg   (ctrlReg)
  );

  qsc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .wrData     (busWrData),
    .count      (countOut),
    .dir        (dirOut),
    .ceilActive (ceilActive)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:  busRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
      ADDR_COUNT: busRdData = countOut;
      ADDR_CEIL:  busRdData = ceilActive;
      default:    busRdData = {{(CNT_W-1){1'b0}}, dirOut};
    endcase
  end
endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busWrEn,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] busWrData,
  input logic             encA,
  input logic             encB,
  input logic             updStrobe,
  input logic [CNT_W-1:0] countOut,
  input logic             dirOut,
  input logic [5:0]       ctrlReg,
  input logic [CNT_W-1:0] ceilActive
);
  logic quiet;
  logic internalOn;
  logic x4On;
  logic x2aOn;

  assign quiet      = !busWrEn && !updStrobe;
  assign internalOn = ctrlReg[0] && ((ctrlReg[4:2] == 3'd0) || ctrlReg[4]);
  assign x4On       = ctrlReg[0] && (ctrlReg[4:2] == 3'd3);
  assign x2aOn      = ctrlReg[0] && (ctrlReg[4:2] == 3'd1);

  assert_internal_step_R2: assert property (@(posedge clk) disable iff (rst)
    internalOn && quiet && (countOut < ceilActive) |=> countOut == $past(countOut) + 1'b1);

  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    internalOn && quiet && (countOut == ceilActive) |=> countOut == '0);

  assert_x4_jump_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    x4On && quiet && (encA != $past(encA)) && (encB != $past(encB)) |=> $stable(countOut));

  assert_x2a_direction_R7: assert property (@(posedge clk) disable iff (rst)
    x2aOn && quiet && (encA != $past(encA)) && (encB == $past(encB))
    |=> dirOut == $past(encA != encB));

  assert_update_clears_R9: assert property (@(posedge clk) disable iff (rst)
    updStrobe |=> countOut == '0);

  assert_reject_write_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrlReg[0] && !updStrobe && busWrEn && (busAddr == 2'd1) && (busWrData > ceilActive)
    |=> $stable(countOut));

  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrlReg[0] && quiet |=> $stable(countOut) && $stable(dirOut));
endmodule

bind quad_step_counter qsc_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_quad_step_counter.sv
`timescale 1ns/100ps
module test_quad_step_counter;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             busWrEn = 1'b0;
  logic [1:0]       busAddr = 2'd0;
  logic [CNT_W-1:0] busWrData = '0;
  logic [CNT_W-1:0] busRdData;
  logic             encA = 1'b0;
  logic             encB = 1'b0;
  logic             updStrobe = 1'b0;
  logic [CNT_W-1:0] countOut;
  logic             dirOut;

  int    vectors = 0;
  int    failures = 0;
  string curReq = "R1";
  int    pos = 0;
  logic  done = 1'b0;

  // reference model state
  logic [CNT_W-1:0] mCount, mCeil, mPre, oldCeil;
  logic             mDir, mEn, mPreEn, mPrevA, mPrevB, upd;
  logic [2:0]       mMode;
  int               sd, dq;

  always #2.5 clk = ~clk;

  quad_step_counter #(.CNT_W(CNT_W)) i_quad_step_counter (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .encA(encA), .encB(encB),
    .updStrobe(updStrobe), .countOut(countOut), .dirOut(dirOut)
  );

  function automatic int grayPos(logic a, logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCount = '0; mDir = 1'b0; mCeil = '1; mPre = '1;
      mEn = 1'b0; mPreEn = 1'b0; mMode = 3'd0;
    end else begin
      sd = 0;
      dq = (grayPos(encA, encB) - grayPos(mPrevA, mPrevB) + 4) % 4;
      if (mEn) begin
        case (mMode)
          3'd1: if (encA != mPrevA) sd = (dq == 1) ? 1 : -1;
          3'd2: if (encB != mPrevB) sd = (dq == 1) ? 1 : -1;
          3'd3: if (dq == 1) sd = 1; else if (dq == 3) sd = -1;
          default: sd = 1;
        endcase
      end
      upd = updStrobe || (busWrEn && busAddr == 2'd0 && busWrData[5]);
      oldCeil = mCeil;
      if (busWrEn && busAddr == 2'd2) begin
        mPre = busWrData;
        if (!mPreEn) mCeil = busWrData;
      end
      if (upd) mCeil = mPre;
      if (sd != 0) mDir = (sd < 0);
      if (upd) mCount = '0;
      else if (busWrEn && busAddr == 2'd1 && busWrData <= oldCeil) mCount = busWrData;
      else if (sd == 1) mCount = (mCount >= oldCeil) ? '0 : mCount + 1'b1;
      else if (sd == -1) mCount = (mCount == '0) ? oldCeil : mCount - 1'b1;
      if (busWrEn && busAddr == 2'd0) begin
        mEn = busWrData[0]; mPreEn = busWrData[1]; mMode = busWrData[4:2];
      end
    end
    mPrevA = encA;
    mPrevB = encB;
  end

  task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({curReq, " count"}, countOut, mCount);
      check({curReq, " dir"}, {{(CNT_W-1){1'b0}}, dirOut}, {{(CNT_W-1){1'b0}}, mDir});
    end
  end

  task automatic busWrite(logic [1:0] a, logic [CNT_W-1:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(string req, logic [1:0] a, logic [CNT_W-1:0] exp);
    @(posedge clk); #1;
    busAddr = a;
    #1 check(req, busRdData, exp);
  endtask

  task automatic encMove(int delta);
    @(posedge clk); #1;
    pos = (pos + delta + 4) % 4;
    case (pos)
      0: {encA, encB} = 2'b00;
      1: {encA, encB} = 2'b01;
      2: {encA, encB} = 2'b11;
      default: {encA, encB} = 2'b10;
    endcase
    @(posedge clk);
  endtask

  task automatic encSteps(int n, int delta);
    for (int i = 0; i < n; i++) encMove(delta);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    busRead("R1 ctrl", 2'd0, 0);
    busRead("R1 count", 2'd1, 0);
    busRead("R1 ceiling", 2'd2, 16'hFFFF);
    busRead("R1 status", 2'd3, 0);

    // R8 direct ceiling, R2/R6 internal counting with wrap
    curReq = "R8";
    busWrite(2'd2, 16'd9);
    busRead("R8 direct ceiling", 2'd2, 16'd9);
    curReq = "R2";
    busWrite(2'd0, 16'd1);
    do @(negedge clk); while (countOut != 16'd9);
    @(negedge clk);
    check("R6 up wrap", countOut, 0);

    // R11 hold while disabled, R10 count writes
    curReq = "R11";
    busWrite(2'd0, 16'd0);
    @(negedge clk); held = countOut;
    repeat (5) @(negedge clk);
    check("R11 hold", countOut, held);
    curReq = "R10";
    busWrite(2'd1, 16'd5);
    busRead("R10 accepted write", 2'd1, 16'd5);
    busWrite(2'd1, 16'd20);
    busRead("R10 rejected write", 2'd1, 16'd5);

    // R2 alias mode 5 counts like internal
    curReq = "R2";
    busWrite(2'd0, 16'd21);
    repeat (6) @(negedge clk);
    check("R2 alias mode", countOut, mCount);
    busWrite(2'd0, 16'd0);
    busWrite(2'd1, 16'd0);

    // R3 x2 on A
    curReq = "R3";
    busWrite(2'd0, 16'd5);
    encSteps(8, 1);
    check("R3 forward", countOut, 16'd4);
    check("R7 up dir", {15'd0, dirOut}, 0);
    encSteps(8, -1);
    check("R3 backward", countOut, 16'd0);
    check("R7 down dir", {15'd0, dirOut}, 1);

    // R4 x2 on B
    curReq = "R4";
    busWrite(2'd0, 16'd9);
    encSteps(8, 1);
    check("R4 forward", countOut, 16'd4);
    encSteps(2, -1);
    check("R4 backward", countOut, 16'd3);
    check("R7 dir after B", {15'd0, dirOut}, 1);

    // R5 x4, R6 down wrap
    curReq = "R5";
    busWrite(2'd0, 16'd13);
    busWrite(2'd1, 16'd0);
    encSteps(1, -1);
    check("R6 down wrap", countOut, 16'd9);
    encSteps(3, 1);
    check("R5 x4 forward", countOut, 16'd2);
    check("R7 up again", {15'd0, dirOut}, 0);
    encSteps(1, 2);
    check("R5 invalid jump", countOut, 16'd2);
    encSteps(1, 1);
    check("R5 after jump", countOut, 16'd3);

    // R8 preload, R9 update events
    curReq = "R8";
    busWrite(2'd0, 16'd15);
    busWrite(2'd2, 16'd3);
    busRead("R8 shadow held", 2'd2, 16'd9);
    curReq = "R9";
    @(posedge clk); #1 updStrobe = 1'b1;
    @(posedge clk); #1 updStrobe = 1'b0;
    @(negedge clk);
    check("R9 strobe clears", countOut, 0);
    busRead("R9 ceiling loaded", 2'd2, 16'd3);
    encSteps(2, 1);
    check("R9 pre count", countOut, 16'd2);
    busWrite(2'd0, 16'd47);
    @(negedge clk);
    check("R9 bit clears count", countOut, 0);
    busRead("R9 bit reads zero", 2'd0, 16'd15);
    curReq = "R6";
    encSteps(4, 1);
    check("R6 wrap at new ceiling", countOut, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end
endmodule